// File: doc/BRIEF.md
# Stride-Learning Stream Buffer Prefetcher

This block sits next to an L1 data cache and listens only to the cache's miss stream. Each miss arrives with the address of the missing access and the instruction address of the load or store that caused it. A small pool of stream buffers tracks these misses. Each buffer remembers the instruction that last touched it, the last block it saw, the stride between the last two blocks, and a two-bit confidence counter. When the confidence is high enough, the buffer asks memory for the block one stride ahead and keeps it until the cache asks for it.

The block answers every miss one cycle later. If a buffer holds the missing block, it returns the data, and that counts as a cache hit. The buffer then gives up that block and moves on along its stride. A miss that no buffer covers, and that comes from an instruction that owns no buffer, takes over the buffer that was allocated longest ago.

The block has one memory port and allows a single request in flight at a time. When several buffers want to prefetch, the lowest-numbered one goes first. The cache arrays and the memory itself sit outside the block.

Top module: `stride_stream_prefetcher`

## Requirements
- R1: One cycle after each cycle with `miss_valid` high, `done_valid` is high. `done_hit` is 1 only if, at the time of the miss, some buffer held valid data whose block address equals the miss block address. In that case `done_data` carries that block's data; otherwise `done_data` is zero. `done_valid` is low in every cycle that does not follow a miss.
- R2: A miss that hits no buffer's data, and whose instruction address matches no allocated buffer, allocates a buffer. Allocation goes in rotating order 0,1,2,3,0,…, so the oldest allocation is replaced first. The new buffer starts with stride +1 block, confidence 2 and next block = miss block + 1, and any data it held is dropped.
- R3: A miss that hits a buffer's data, or else matches a buffer's instruction address, references that buffer (the lowest-numbered one when several qualify). The new stride is the miss block minus the buffer's last block, modulo 2^27. Confidence goes up by 1 (saturating at 3) when the new stride equals the old one, and down by 1 (saturating at 0) when it does not. The next block becomes miss block + new stride.
- R4: A buffer requests a prefetch only while its confidence is 2 or more, it holds no valid data, and it has no request in flight.
- R5: At most one memory request is in flight. `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen, and no new request starts before the response (`mem_rsp_valid`) arrives.
- R6: When several buffers want to prefetch, the lowest-numbered buffer is granted.
- R7: A response is stored only if its block still equals the requesting buffer's next block after that cycle's update. Otherwise it is discarded, and the buffer does not hold the block.
- R8: A referenced buffer drops its data. A second miss to the same block right after a hit does not hit.
- R9: During and right after reset, no buffer holds data, and `done_valid`, `done_hit` and `mem_req_valid` are low.
- R10: Addresses are compared on 32-byte blocks, using address bits [31:5]. `mem_req_addr` is always block aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | L1 miss present this cycle |
| miss_addr | input | 32 | Byte address of the miss |
| miss_pc | input | 32 | Instruction address of the missing access |
| done_valid | output | 1 | Lookup answer for the previous cycle's miss |
| done_hit | output | 1 | A buffer supplied the block |
| done_data | output | 64 | Block data on a hit, zero otherwise |
| mem_req_valid | output | 1 | Prefetch request to memory |
| mem_req_addr | output | 32 | Block-aligned prefetch address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Response data valid |
| mem_rsp_data | input | 64 | Response block data |

## Verification
The bench builds the block with its defaults: four buffers, 32-byte lines and 64-bit block data. With only four buffers, a handful of instructions is enough to wrap the rotating allocation and evict a buffer that still holds a prefetched block. Holding `mem_req_ready` low keeps one request parked while other buffers gain confidence, which exposes both the lowest-index grant and a response that arrives after its buffer has moved to a new stride. The sequences cover positive, zero and negative strides, and a stride change that drops confidence below the prefetch threshold.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    ISS_IDLE = 2'd0,
    ISS_REQ  = 2'd1,
    ISS_WAIT = 2'd2
  } iss_state_t;

  localparam int CONF_W = 2;
  localparam logic [CONF_W-1:0] CONF_MAX  = 2'd3;
  localparam logic [CONF_W-1:0] CONF_ON   = 2'd2;
  localparam logic [CONF_W-1:0] CONF_INIT = 2'd2;
endpackage

// File: rtl/pf_lookup.sv
module pf_lookup #(
  parameter int NBUF  = 4,
  parameter int BLK_W = 27,
  parameter int PC_W  = 32
) (
  input  logic [BLK_W-1:0]            blk,
  input  logic [PC_W-1:0]             pc,
  input  logic [NBUF-1:0]             busy,
  input  logic [NBUF-1:0]             dvalid,
  input  logic [NBUF-1:0][BLK_W-1:0]  tags,
  input  logic [NBUF-1:0][PC_W-1:0]   pcs,
  output logic                        tag_hit,
  output logic [$clog2(NBUF)-1:0]     tag_id,
  output logic                        pc_hit,
  output logic [$clog2(NBUF)-1:0]     pc_id
);
  localparam int ID_W = $clog2(NBUF);

  logic [NBUF-1:0] tag_m;
  logic [NBUF-1:0] pc_m;

  for (genvar i = 0; i < NBUF; i++) begin : g_cmp
    assign tag_m[i] = dvalid[i] && (tags[i] == blk);
    assign pc_m[i]  = busy[i] && (pcs[i] == pc);
  end

  // lowest index wins: scan downward, last write sticks
  always_comb begin
    tag_hit = 1'b0;
    tag_id  = '0;
    pc_hit  = 1'b0;
    pc_id   = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (tag_m[i]) begin
        tag_hit = 1'b1;
        tag_id  = ID_W'(i);
      end
      if (pc_m[i]) begin
        pc_hit = 1'b1;
        pc_id  = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/pf_buffer.sv
module pf_buffer
  import pf_pkg::*;
#(
  parameter int BLK_W  = 27,
  parameter int PC_W   = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_en,
  input  logic              alloc_en,
  input  logic [BLK_W-1:0]  blk,
  input  logic [PC_W-1:0]   pc,
  input  logic              fill_en,
  input  logic [BLK_W-1:0]  fill_blk,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              inflight_here,
  output logic              busy,
  output logic [PC_W-1:0]   owner_pc,
  output logic              dvalid,
  output logic [BLK_W-1:0]  tag,
  output logic [DATA_W-1:0] data,
  output logic [BLK_W-1:0]  next_blk,
  output logic              want
);
  logic [BLK_W-1:0]  last_blk, stride;
  logic [CONF_W-1:0] conf;

  logic              busy_d, dvalid_d;
  logic [PC_W-1:0]   pc_d;
  logic [BLK_W-1:0]  last_d, stride_d, next_d, tag_d, step;
  logic [CONF_W-1:0] conf_d;
  logic              take_fill;

  assign step = blk - last_blk;

  always_comb begin
    busy_d   = busy;
    pc_d     = owner_pc;
    last_d   = last_blk;
    stride_d = stride;
    conf_d   = conf;
    next_d   = next_blk;
    dvalid_d = dvalid;
    tag_d    = tag;
    if (alloc_en) begin
      busy_d   = 1'b1;
      pc_d     = pc;
      last_d   = blk;
      stride_d = BLK_W'(1);
      conf_d   = CONF_INIT;
      next_d   = blk + BLK_W'(1);
      dvalid_d = 1'b0;
    end else if (ref_en) begin
      pc_d     = pc;
      last_d   = blk;
      stride_d = step;
      if (step == stride)
        conf_d = (conf == CONF_MAX) ? conf : conf + 1'b1;
      else
        conf_d = (conf == '0) ? conf : conf - 1'b1;
      next_d   = blk + step;
      dvalid_d = 1'b0;
    end
    take_fill = fill_en && (fill_blk == next_d);
    if (take_fill) begin
      dvalid_d = 1'b1;
      tag_d    = fill_blk;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      owner_pc <= '0;
      last_blk <= '0;
      stride   <= '0;
      conf     <= '0;
      next_blk <= '0;
      dvalid   <= 1'b0;
      tag      <= '0;
    end else begin
      busy     <= busy_d;
      owner_pc <= pc_d;
      last_blk <= last_d;
      stride   <= stride_d;
      conf     <= conf_d;
      next_blk <= next_d;
      dvalid   <= dvalid_d;
      tag      <= tag_d;
    end
  end

  // data storage kept free of reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (take_fill) data <= fill_data;
  end

  assign want = busy && (conf >= CONF_ON) && !dvalid && !inflight_here;

  // R2: fresh allocation starts empty and aims one block ahead
  a_r2_alloc_init: assert property (@(posedge clk) disable iff (rst)
    alloc_en && !fill_en |=> busy && !dvalid && next_blk == $past(blk) + BLK_W'(1));

  // R3: confidence moves by at most one step per reference
  a_r3_conf_step: assert property (@(posedge clk) disable iff (rst)
    ref_en |=> ((conf >= $past(conf)) ? (conf - $past(conf)) : ($past(conf) - conf)) <= 2'd1);

  // R7: stored data always belongs to the block the buffer is aiming at
  a_r7_fill_tag: assert property (@(posedge clk) disable iff (rst)
    $rose(dvalid) |-> tag == next_blk);

  // R8: a reference gives up the held block
  a_r8_consume: assert property (@(posedge clk) disable iff (rst)
    ref_en && !fill_en |=> !dvalid);
endmodule

// File: rtl/pf_issue.sv
module pf_issue
  import pf_pkg::*;
#(
  parameter int NBUF  = 4,
  parameter int BLK_W = 27
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NBUF-1:0]            want,
  input  logic [NBUF-1:0][BLK_W-1:0] next_arr,
  input  logic                       mem_req_ready,
  input  logic                       mem_rsp_valid,
  output logic                       mem_req_valid,
  output logic [BLK_W-1:0]           req_blk,
  output logic                       fill_en,
  output logic [$clog2(NBUF)-1:0]    fill_id,
  output logic                       inflight
);
  localparam int ID_W = $clog2(NBUF);

  iss_state_t      state;
  logic [ID_W-1:0] id_q, grant;
  logic            any_want;

  always_comb begin
    grant    = '0;
    any_want = |want;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (want[i]) grant = ID_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ISS_IDLE;
      id_q          <= '0;
      req_blk       <= '0;
      mem_req_valid <= 1'b0;
    end else begin
      case (state)
        ISS_IDLE: if (any_want) begin
          state         <= ISS_REQ;
          id_q          <= grant;
          req_blk       <= next_arr[grant];
          mem_req_valid <= 1'b1;
        end
        ISS_REQ: if (mem_req_ready) begin
          state         <= ISS_WAIT;
          mem_req_valid <= 1'b0;
        end
        ISS_WAIT: if (mem_rsp_valid) state <= ISS_IDLE;
        default: state <= ISS_IDLE;
      endcase
    end
  end

  assign fill_en  = (state == ISS_WAIT) && mem_rsp_valid;
  assign fill_id  = id_q;
  assign inflight = (state != ISS_IDLE);

  // R5: request held steady until accepted
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(req_blk));

  // R5: nothing new is requested while a response is awaited
  a_r5_single: assert property (@(posedge clk) disable iff (rst)
    state == ISS_WAIT |-> !mem_req_valid);

  // R6: no lower-numbered buffer was waiting when a grant was made
  a_r6_lowest: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_valid) |-> ($past(want) & ((NBUF'(1) << id_q) - NBUF'(1))) == '0);
endmodule

// File: rtl/stride_stream_prefetcher.sv
module stride_stream_prefetcher #(
  parameter int ADDR_W     = 32,
  parameter int PC_W       = 32,
  parameter int DATA_W     = 64,
  parameter int NBUF       = 4,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [PC_W-1:0]   miss_pc,
  output logic              done_valid,
  output logic              done_hit,
  output logic [DATA_W-1:0] done_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int ID_W  = $clog2(NBUF);

  logic [BLK_W-1:0]              blk;
  logic [NBUF-1:0]               busy_v, dv_v, want_v, ref_v, alloc_v, fill_v, infl_v;
  logic [NBUF-1:0][BLK_W-1:0]    tag_a, next_a;
  logic [NBUF-1:0][PC_W-1:0]     pc_a;
  logic [NBUF-1:0][DATA_W-1:0]   data_a;
  logic                          tag_hit, pc_hit, fill_en, inflight;
  logic [ID_W-1:0]               tag_id, pc_id, fill_id, alloc_ptr;
  logic [BLK_W-1:0]              req_blk;

  assign blk = miss_addr[ADDR_W-1:OFF_W];

  pf_lookup #(.NBUF(NBUF), .BLK_W(BLK_W), .PC_W(PC_W)) u_lookup (
    .blk(blk), .pc(miss_pc), .busy(busy_v), .dvalid(dv_v),
    .tags(tag_a), .pcs(pc_a),
    .tag_hit(tag_hit), .tag_id(tag_id), .pc_hit(pc_hit), .pc_id(pc_id)
  );

  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    assign ref_v[i]   = miss_valid && (tag_hit ? (tag_id == ID_W'(i))
                                               : (pc_hit && pc_id == ID_W'(i)));
    assign alloc_v[i] = miss_valid && !tag_hit && !pc_hit && (alloc_ptr == ID_W'(i));
    assign fill_v[i]  = fill_en && (fill_id == ID_W'(i));
    assign infl_v[i]  = inflight && (fill_id == ID_W'(i));

    pf_buffer #(.BLK_W(BLK_W), .PC_W(PC_W), .DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst(rst),
      .ref_en(ref_v[i]), .alloc_en(alloc_v[i]),
      .blk(blk), .pc(miss_pc),
      .fill_en(fill_v[i]), .fill_blk(req_blk), .fill_data(mem_rsp_data),
      .inflight_here(infl_v[i]),
      .busy(busy_v[i]), .owner_pc(pc_a[i]), .dvalid(dv_v[i]),
      .tag(tag_a[i]), .data(data_a[i]), .next_blk(next_a[i]), .want(want_v[i])
    );
  end

  pf_issue #(.NBUF(NBUF), .BLK_W(BLK_W)) u_issue (
    .clk(clk), .rst(rst), .want(want_v), .next_arr(next_a),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_req_valid(mem_req_valid), .req_blk(req_blk),
    .fill_en(fill_en), .fill_id(fill_id), .inflight(inflight)
  );

  assign mem_req_addr = {req_blk, {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      alloc_ptr  <= '0;
      done_valid <= 1'b0;
      done_hit   <= 1'b0;
      done_data  <= '0;
    end else begin
      if (miss_valid && !tag_hit && !pc_hit)
        alloc_ptr <= (alloc_ptr == ID_W'(NBUF - 1)) ? '0 : alloc_ptr + 1'b1;
      done_valid <= miss_valid;
      done_hit   <= miss_valid && tag_hit;
      done_data  <= (miss_valid && tag_hit) ? data_a[tag_id] : '0;
    end
  end

  // R1: every miss is answered on the following cycle
  a_r1_done_follows: assert property (@(posedge clk) disable iff (rst)
    miss_valid |=> done_valid);

  // R1: no answer without a miss
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !miss_valid |=> !done_valid && !done_hit);
endmodule

// File: tb/sim_stride_stream_prefetcher.sv
module sim_stride_stream_prefetcher;
  localparam int BW = 27;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic [31:0] miss_pc = '0;
  logic        done_valid, done_hit, mem_req_valid;
  logic [63:0] done_data;
  logic [31:0] mem_req_addr;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  stride_stream_prefetcher u0 (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_pc(miss_pc), .done_valid(done_valid), .done_hit(done_hit),
    .done_data(done_data), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  always #5 clk = ~clk;

  int    n_run = 0, n_fail = 0, cyc = 0;
  string cur_req = "R9";
  int    rdy_mode = 0;

  function automatic logic [63:0] mdat(logic [BW-1:0] b);
    return {32'(b) * 32'd7 + 32'd3, 32'(b) ^ 32'h5A5A_0F0F};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic          m_busy[4], m_dv[4];
  logic [31:0]   m_pc[4];
  logic [BW-1:0] m_last[4], m_sd[4], m_nx[4], m_tg[4];
  logic [63:0]   m_dat[4];
  int            m_cf[4];
  int            m_ptr, m_st, m_fid;
  logic [BW-1:0] m_fblk;
  logic          e_dv, e_hit, e_rv;
  logic [63:0]   e_dat;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_busy[i] = 0; m_dv[i] = 0; m_cf[i] = 0; m_pc[i] = '0;
        m_last[i] = '0; m_sd[i] = '0; m_nx[i] = '0; m_tg[i] = '0; m_dat[i] = '0;
      end
      m_ptr = 0; m_st = 0; m_fid = 0; m_fblk = '0;
      e_dv = 0; e_hit = 0; e_rv = 0; e_dat = '0;
    end else begin
      logic [BW-1:0] b, ns, gblk;
      int h, p, g, t;
      bit fe;
      b = miss_addr[31:5];
      h = -1; p = -1; g = -1;
      for (int i = 0; i < 4; i++) if (h < 0 && m_dv[i] && m_tg[i] == b) h = i;
      for (int i = 0; i < 4; i++) if (p < 0 && m_busy[i] && m_pc[i] == miss_pc) p = i;
      for (int i = 0; i < 4; i++)
        if (g < 0 && m_busy[i] && m_cf[i] >= 2 && !m_dv[i] && !(m_st != 0 && m_fid == i)) g = i;
      gblk  = (g >= 0) ? m_nx[g] : '0;
      e_dv  = miss_valid;
      e_hit = miss_valid && h >= 0;
      e_dat = (miss_valid && h >= 0) ? m_dat[h] : 64'd0;
      fe    = (m_st == 2) && mem_rsp_valid;
      if (miss_valid) begin
        t = (h >= 0) ? h : p;
        if (t >= 0) begin
          ns = b - m_last[t];
          if (ns == m_sd[t]) begin
            if (m_cf[t] < 3) m_cf[t]++;
          end else if (m_cf[t] > 0) m_cf[t]--;
          m_sd[t] = ns; m_last[t] = b; m_pc[t] = miss_pc;
          m_nx[t] = b + ns; m_dv[t] = 0;
        end else begin
          m_busy[m_ptr] = 1; m_pc[m_ptr] = miss_pc; m_last[m_ptr] = b;
          m_sd[m_ptr] = 1; m_cf[m_ptr] = 2; m_nx[m_ptr] = b + 1; m_dv[m_ptr] = 0;
          m_ptr = (m_ptr + 1) % 4;
        end
      end
      if (fe && m_fblk == m_nx[m_fid]) begin
        m_dv[m_fid] = 1; m_tg[m_fid] = m_fblk; m_dat[m_fid] = mem_rsp_data;
      end
      case (m_st)
        0: if (g >= 0) begin m_st = 1; m_fid = g; m_fblk = gblk; e_rv = 1; end
        1: if (mem_req_ready) begin m_st = 2; e_rv = 0; end
        default: if (mem_rsp_valid) m_st = 0;
      endcase
    end
  end

  // ---------------- per-cycle comparison and watchdog ----------------
  logic [31:0] req_log[$];
  logic        prev_rv = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      check(done_valid === e_dv && done_hit === e_hit && done_data === e_dat,
            cur_req, "lookup answer", {done_valid, done_hit, done_data[61:0]},
            {e_dv, e_hit, e_dat[61:0]});
      check(mem_req_valid === e_rv && (!e_rv || mem_req_addr === {m_fblk, 5'b0}),
            cur_req, "memory request", {31'd0, mem_req_valid, mem_req_addr},
            {31'd0, e_rv, m_fblk, 5'b0});
      if (mem_req_valid && !prev_rv) req_log.push_back(mem_req_addr);
      prev_rv = mem_req_valid;
    end
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // ---------------- memory responder ----------------
  int            m_cnt = 0;
  logic [BW-1:0] m_paddr = '0;
  always @(negedge clk) begin
    if (rst) begin
      mem_req_ready = 0; mem_rsp_valid = 0; m_cnt = 0;
    end else begin
      mem_rsp_valid = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin mem_rsp_valid = 1; mem_rsp_data = mdat(m_paddr); end
      end
      mem_req_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (cyc % 3 != 0) : 1'b0;
      if (mem_req_valid && mem_req_ready && m_cnt == 0 && !mem_rsp_valid) begin
        m_cnt = 3; m_paddr = mem_req_addr[31:5];
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic miss(input logic [31:0] a, input logic [31:0] pc);
    @(negedge clk);
    miss_valid = 1; miss_addr = a; miss_pc = pc;
    @(negedge clk);
    miss_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int nreq, base;
    idle(3);
    // R9: reset state
    check(!done_valid && !done_hit && !mem_req_valid, "R9", "reset outputs",
          {61'd0, done_valid, done_hit, mem_req_valid}, 64'd0);
    @(negedge clk); rst = 0;
    idle(2);
    check(!done_valid && !mem_req_valid, "R9", "after reset",
          {62'd0, done_valid, mem_req_valid}, 64'd0);

    // R2 / R1: allocate on blk 100, unit prefetch of 101, hit inside the line (R10)
    cur_req = "R2"; rdy_mode = 1;
    miss(32'(100) << 5, 32'h1000);
    check(done_valid && !done_hit, "R1", "first miss uncovered", {62'd0, done_valid, done_hit}, 64'd2);
    idle(12);
    cur_req = "R10";
    miss((32'(101) << 5) + 32'h14, 32'h1000);
    check(done_hit && done_data == mdat(101), "R10", "hit at line offset", done_data, mdat(101));
    // R8: same block again straight after the hit
    cur_req = "R8";
    miss(32'(101) << 5, 32'h1000);
    check(!done_hit, "R8", "consumed block", {63'd0, done_hit}, 64'd0);
    idle(12);
    miss(32'(101) << 5, 32'h1000);
    check(done_hit && done_data == mdat(101), "R8", "zero-stride refetch", done_data, mdat(101));
    idle(12);

    // R3 / R4: stride of three blocks
    cur_req = "R3";
    miss(32'(500) << 5, 32'h2000);
    idle(12);
    miss(32'(503) << 5, 32'h2000);
    cur_req = "R4"; nreq = req_log.size();
    idle(12);
    check(req_log.size() == nreq, "R4", "no prefetch at low confidence",
          64'(req_log.size()), 64'(nreq));
    cur_req = "R3";
    miss(32'(506) << 5, 32'h2000);
    idle(12);
    miss(32'(509) << 5, 32'h2000);
    check(done_hit && done_data == mdat(509), "R3", "stride-3 hit", done_data, mdat(509));
    idle(12);

    // R5 / R7 / R6: park a request, move its buffer, queue two more buffers
    cur_req = "R5"; rdy_mode = 2;
    miss(32'(700) << 5, 32'h3000);
    idle(3);
    miss(32'(710) << 5, 32'h3000);
    miss(32'(800) << 5, 32'h4000);
    miss(32'(900) << 5, 32'h5000);
    idle(3);
    check(mem_req_valid && mem_req_addr == (32'(701) << 5), "R5", "held request",
          {31'd0, mem_req_valid, mem_req_addr}, {31'd0, 1'b1, 32'(701) << 5});
    cur_req = "R6"; base = req_log.size(); rdy_mode = 0;
    idle(20);
    check(req_log.size() >= base + 2 && req_log[base] == (32'(901) << 5), "R6",
          "lowest buffer first", 64'(req_log[base]), 64'(32'(901) << 5));
    check(req_log.size() >= base + 2 && req_log[base + 1] == (32'(801) << 5), "R6",
          "second grant", 64'(req_log[base + 1]), 64'(32'(801) << 5));
    cur_req = "R7";
    miss(32'(701) << 5, 32'h7000);
    check(!done_hit, "R7", "stale response discarded", {63'd0, done_hit}, 64'd0);
    idle(10);

    // R2: buffer 0 was overwritten, its block is gone
    cur_req = "R2";
    miss(32'(101) << 5, 32'h9000);
    check(!done_hit, "R2", "oldest buffer evicted", {63'd0, done_hit}, 64'd0);
    idle(10);

    // R3: negative stride
    cur_req = "R3"; rdy_mode = 1;
    miss(32'(2000) << 5, 32'hA000);
    idle(2);
    miss(32'(1998) << 5, 32'hA000);
    idle(2);
    miss(32'(1996) << 5, 32'hA000);
    idle(12);
    miss(32'(1994) << 5, 32'hA000);
    check(done_hit && done_data == mdat(1994), "R3", "negative stride hit", done_data, mdat(1994));
    idle(10);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule